// File: doc/BRIEF.md
# Decoupled Command Queue Front End with Token-Based Ordering

This block sits between a host that streams commands and three execution engines: one that moves data in, one that moves data out, and one that computes. Each incoming command carries a two-bit opcode that picks its engine. It is written into that engine's private FIFO, so the three engines drain their own work concurrently and in parallel with the host. Within one queue, commands issue strictly in arrival order. That is the only hazard protection a single queue needs.

Ordering between queues is never inferred from addresses. Each command instead carries four software-set flag bits. A "wait" bit holds the command at the head of its queue until a token is present in the matching cross-queue counter, and taking the token decrements that counter. A "signal" bit adds a token when the engine reports completion of that command. Four directed counters exist: load to execute, execute to load, execute to store and store to execute. Completions arrive as single-cycle pulses, and each queue remembers the signal bits of its issued commands in order until they complete. A counter that is already full saturates on a further signal and raises a sticky error output.

Top module: `cq_frontend`

## Requirements
- R1: Opcode 0 routes a command to the load queue, opcode 1 to the store queue and opcode 2 to the execute queue. The command's data appears on that queue's issue port and on no other.
- R2: Opcode 3 is always accepted and discarded. It raises no issue valid and leaves every queue's contents unchanged.
- R3: Each queue issues its commands in arrival order.
- R4: `cmd_ready_o` is low exactly when the command on the input targets a full queue. Commands for other queues are still accepted in that state.
- R5: Flag bit 0 means "wait". For the load queue it waits on the execute-to-load counter, and for the store queue on the execute-to-store counter. For the execute queue, bit 0 waits on the load-to-execute counter and bit 2 waits on the store-to-execute counter. A waiting head is not offered until every counter it needs is non-zero, and each such counter is decremented by one when the command issues.
- R6: Flag bit 1 means "signal". When a load or store command completes with it set, the load-to-execute or store-to-execute counter increments. When an execute command completes, bit 1 increments the execute-to-load counter and bit 3 increments the execute-to-store counter.
- R7: For the load and store queues, flag bits 3 and 2 have no effect on any counter.
- R8: With counter width W, a counter holds at most 2^W-1. A signal arriving at that value leaves the counter unchanged and sets `tok_err_o`, which stays high until reset.
- R9: An issue that consumes a token and a completion that produces a token for the same counter in the same cycle leave that counter unchanged.
- R10: While an issue port has valid high and ready low, valid stays high and the data stays stable.
- R11: After reset all counters are zero, all queues are empty, no issue valid is high, `tok_err_o` is low and `cmd_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Host command valid |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| cmd_op_i | input | 2 | Opcode: 0 load, 1 store, 2 execute, 3 discard |
| cmd_flags_i | input | 4 | Wait/signal dependency flags |
| cmd_data_i | input | DW | Command payload |
| ld_valid_o | output | 1 | Load issue valid |
| ld_ready_i | input | 1 | Load engine accepts |
| ld_data_o | output | DW | Load issue payload |
| st_valid_o | output | 1 | Store issue valid |
| st_ready_i | input | 1 | Store engine accepts |
| st_data_o | output | DW | Store issue payload |
| ex_valid_o | output | 1 | Execute issue valid |
| ex_ready_i | input | 1 | Execute engine accepts |
| ex_data_o | output | DW | Execute issue payload |
| ld_done_i | input | 1 | Oldest issued load completed |
| st_done_i | input | 1 | Oldest issued store completed |
| ex_done_i | input | 1 | Oldest issued execute completed |
| tok_err_o | output | 1 | Sticky counter overflow flag |

## Verification
The load-to-execute counter can be decremented by an execute issue and incremented by a load completion in the same cycle. The bench provokes this by holding one token and then raising the execute ready together with the completion pulse of a second signalling load. It judges the result by whether the next waiting execute command is still offered with exactly one token left, and whether the command after it is then stalled. Saturation is driven to the edge with a two-bit counter: three signals leave the error low, the fourth sets it, and exactly three waiting execute commands are then released.

// File: rtl/cq_pkg.sv
package cq_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_EXEC  = 2'd2,
        OP_NONE  = 2'd3
    } cq_op_e;

    localparam int FLAG_W = 4;
    typedef logic [FLAG_W-1:0] cq_flags_t;

    // flag bit positions
    localparam int FB_WAIT_A = 0;
    localparam int FB_SIG_A  = 1;
    localparam int FB_WAIT_B = 2;
    localparam int FB_SIG_B  = 3;

    // lane indices
    localparam int NQ   = 3;
    localparam int Q_LD = 0;
    localparam int Q_ST = 1;
    localparam int Q_EX = 2;

    // token counter indices
    localparam int NT   = 4;
    localparam int T_LE = 0;
    localparam int T_EL = 1;
    localparam int T_ES = 2;
    localparam int T_SE = 3;

    function automatic logic deps_met(cq_flags_t f, logic have_a, logic have_b);
        return (!f[FB_WAIT_A] || have_a) && (!f[FB_WAIT_B] || have_b);
    endfunction
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_no_push_full_r4: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_no_pop_empty_r3: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/cq_token.sv
module cq_token #(
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic nz,
    output logic ovf
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W-1:0] cnt;

    assign nz = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (inc && !dec) begin
                if (cnt == MAXV) ovf <= 1'b1;
                else             cnt <= cnt + 1'b1;
            end else if (dec && !inc) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        dec |-> nz);
    p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt == MAXV && inc && !dec) |=> (cnt == MAXV && ovf));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    p_net_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (inc && dec) |=> $stable(cnt));
endmodule

// File: rtl/cq_lane.sv
module cq_lane
    import cq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int INFL  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  cq_flags_t     push_flags,
    input  logic [DW-1:0] push_data,
    output logic          full_o,
    output cq_flags_t     head_flags_o,
    input  logic          deps_ok_i,
    output logic          issue_valid_o,
    input  logic          issue_ready_i,
    output logic [DW-1:0] issue_data_o,
    output logic          fire_o,
    input  logic          done_i,
    output logic          done_fire_o,
    output cq_flags_t     done_flags_o
);
    localparam int CMD_W = FLAG_W + DW;

    logic [CMD_W-1:0] head;
    logic             cmd_empty, inf_empty, inf_full;

    cq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd (
        .clk(clk), .rst(rst),
        .push(push), .din({push_flags, push_data}),
        .pop(fire_o), .dout(head),
        .empty(cmd_empty), .full(full_o)
    );

    assign head_flags_o  = head[CMD_W-1 -: FLAG_W];
    assign issue_data_o  = head[DW-1:0];
    assign issue_valid_o = !cmd_empty && !inf_full && deps_ok_i;
    assign fire_o        = issue_valid_o && issue_ready_i;
    assign done_fire_o   = done_i && !inf_empty;

    // signal bits of issued commands, kept in issue order
    cq_fifo #(.W(FLAG_W), .DEPTH(INFL)) u_inflight (
        .clk(clk), .rst(rst),
        .push(fire_o), .din(head_flags_o),
        .pop(done_fire_o), .dout(done_flags_o),
        .empty(inf_empty), .full(inf_full)
    );

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_o && !issue_ready_i) |=> (issue_valid_o && $stable(issue_data_o)));
endmodule

// File: rtl/cq_frontend.sv
module cq_frontend
    import cq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int INFL  = 2,
    parameter int CNT_W = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid_i,
    output logic          cmd_ready_o,
    input  logic [1:0]    cmd_op_i,
    input  logic [3:0]    cmd_flags_i,
    input  logic [DW-1:0] cmd_data_i,
    output logic          ld_valid_o,
    input  logic          ld_ready_i,
    output logic [DW-1:0] ld_data_o,
    output logic          st_valid_o,
    input  logic          st_ready_i,
    output logic [DW-1:0] st_data_o,
    output logic          ex_valid_o,
    input  logic          ex_ready_i,
    output logic [DW-1:0] ex_data_o,
    input  logic          ld_done_i,
    input  logic          st_done_i,
    input  logic          ex_done_i,
    output logic          tok_err_o
);
    cq_op_e          op;
    logic [NQ-1:0]   q_push, q_full, q_ok, q_valid, q_ready, q_fire, q_done, q_dfire;
    cq_flags_t       q_hflags [NQ];
    cq_flags_t       q_dflags [NQ];
    logic [DW-1:0]   q_data   [NQ];
    logic [NT-1:0]   t_inc, t_dec, t_nz, t_ovf;

    assign op = cq_op_e'(cmd_op_i);

    always_comb begin
        cmd_ready_o = 1'b1;
        if (op != OP_NONE) cmd_ready_o = !q_full[cmd_op_i];
    end

    assign q_ready = {ex_ready_i, st_ready_i, ld_ready_i};
    assign q_done  = {ex_done_i, st_done_i, ld_done_i};

    // load/store see only the execute-side counter; bits 3:2 unused there
    assign q_ok[Q_LD] = deps_met(q_hflags[Q_LD], t_nz[T_EL], 1'b1);
    assign q_ok[Q_ST] = deps_met(q_hflags[Q_ST], t_nz[T_ES], 1'b1);
    assign q_ok[Q_EX] = deps_met(q_hflags[Q_EX], t_nz[T_LE], t_nz[T_SE]);

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_lane
            assign q_push[q] = cmd_valid_i && cmd_ready_o && (cmd_op_i == 2'(q));
            cq_lane #(.DW(DW), .DEPTH(DEPTH), .INFL(INFL)) u_lane (
                .clk(clk), .rst(rst),
                .push(q_push[q]), .push_flags(cmd_flags_i), .push_data(cmd_data_i),
                .full_o(q_full[q]), .head_flags_o(q_hflags[q]),
                .deps_ok_i(q_ok[q]),
                .issue_valid_o(q_valid[q]), .issue_ready_i(q_ready[q]),
                .issue_data_o(q_data[q]), .fire_o(q_fire[q]),
                .done_i(q_done[q]), .done_fire_o(q_dfire[q]),
                .done_flags_o(q_dflags[q])
            );
        end
    endgenerate

    // token producers (completion) and consumers (issue)
    assign t_inc[T_LE] = q_dfire[Q_LD] && q_dflags[Q_LD][FB_SIG_A];
    assign t_inc[T_SE] = q_dfire[Q_ST] && q_dflags[Q_ST][FB_SIG_A];
    assign t_inc[T_EL] = q_dfire[Q_EX] && q_dflags[Q_EX][FB_SIG_A];
    assign t_inc[T_ES] = q_dfire[Q_EX] && q_dflags[Q_EX][FB_SIG_B];

    assign t_dec[T_EL] = q_fire[Q_LD] && q_hflags[Q_LD][FB_WAIT_A];
    assign t_dec[T_ES] = q_fire[Q_ST] && q_hflags[Q_ST][FB_WAIT_A];
    assign t_dec[T_LE] = q_fire[Q_EX] && q_hflags[Q_EX][FB_WAIT_A];
    assign t_dec[T_SE] = q_fire[Q_EX] && q_hflags[Q_EX][FB_WAIT_B];

    generate
        for (genvar t = 0; t < NT; t++) begin : g_tok
            cq_token #(.CNT_W(CNT_W)) u_tok (
                .clk(clk), .rst(rst),
                .inc(t_inc[t]), .dec(t_dec[t]),
                .nz(t_nz[t]), .ovf(t_ovf[t])
            );
        end
    endgenerate

    assign tok_err_o = |t_ovf;

    assign ld_valid_o = q_valid[Q_LD];
    assign st_valid_o = q_valid[Q_ST];
    assign ex_valid_o = q_valid[Q_EX];
    assign ld_data_o  = q_data[Q_LD];
    assign st_data_o  = q_data[Q_ST];
    assign ex_data_o  = q_data[Q_EX];

    p_discard_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && op == OP_NONE) |-> (cmd_ready_o && q_push == '0));
    p_one_target_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_push));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        tok_err_o |=> tok_err_o);
    p_wait_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (ex_valid_o && q_hflags[Q_EX][FB_WAIT_A]) |-> t_nz[T_LE]);
endmodule

// File: tb/cq_frontend_tb.sv
module cq_frontend_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid, cmd_ready;
    logic [1:0] cmd_op;
    logic [3:0] cmd_flags;
    logic [7:0] cmd_data;
    logic       ld_valid, st_valid, ex_valid;
    logic       ld_ready, st_ready, ex_ready;
    logic [7:0] ld_data, st_data, ex_data;
    logic       ld_done, st_done, ex_done;
    logic       tok_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cq_frontend #(.DW(8), .DEPTH(4), .INFL(2), .CNT_W(2)) u_dut (
        .clk(clk), .rst(rst),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
        .cmd_op_i(cmd_op), .cmd_flags_i(cmd_flags), .cmd_data_i(cmd_data),
        .ld_valid_o(ld_valid), .ld_ready_i(ld_ready), .ld_data_o(ld_data),
        .st_valid_o(st_valid), .st_ready_i(st_ready), .st_data_o(st_data),
        .ex_valid_o(ex_valid), .ex_ready_i(ex_ready), .ex_data_o(ex_data),
        .ld_done_i(ld_done), .st_done_i(st_done), .ex_done_i(ex_done),
        .tok_err_o(tok_err)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int qv(int q);
        return (q == 0) ? int'(ld_valid) : (q == 1) ? int'(st_valid) : int'(ex_valid);
    endfunction

    function automatic int qd(int q);
        return (q == 0) ? int'(ld_data) : (q == 1) ? int'(st_data) : int'(ex_data);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // all tasks start and end at a falling edge
    task automatic do_reset();
        rst = 1'b1; cmd_valid = 0; cmd_op = 0; cmd_flags = 0; cmd_data = 0;
        ld_ready = 0; st_ready = 0; ex_ready = 0;
        ld_done = 0; st_done = 0; ex_done = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(int op, logic [3:0] f, int d);
        cmd_valid = 1; cmd_op = 2'(op); cmd_flags = f; cmd_data = 8'(d);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic take(int q, int exp, string tag);
        chk({tag, " valid"}, qv(q), 1);
        chk({tag, " data"}, qd(q), exp);
        if (q == 0) ld_ready = 1; else if (q == 1) st_ready = 1; else ex_ready = 1;
        @(negedge clk);
        ld_ready = 0; st_ready = 0; ex_ready = 0;
    endtask

    task automatic done(int q);
        if (q == 0) ld_done = 1; else if (q == 1) st_done = 1; else ex_done = 1;
        @(negedge clk);
        ld_done = 0; st_done = 0; ex_done = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R11 reset state
        chk("R11 ready", cmd_ready, 1);
        chk("R11 ld_valid", ld_valid, 0);
        chk("R11 st_valid", st_valid, 0);
        chk("R11 ex_valid", ex_valid, 0);
        chk("R11 err", tok_err, 0);

        // R1 steering sweep over opcode and payload
        for (int op = 0; op < 3; op++) begin
            for (int k = 0; k < 4; k++) begin
                int d;
                d = op * 40 + k * 7 + 1;
                push(op, 4'b0000, d);
                for (int q = 0; q < 3; q++)
                    chk("R1 route valid", qv(q), (q == op) ? 1 : 0);
                take(op, d, "R1 route");
                done(op);
            end
        end

        // R2 opcode 3 discarded
        cmd_op = 2'd3; cmd_valid = 1; #1;
        chk("R2 ready op3", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 0;
        for (int q = 0; q < 3; q++) chk("R2 no valid", qv(q), 0);
        push(0, 4'b0000, 200);
        take(0, 200, "R2 queue untouched");
        done(0);

        // R3/R4 fill load queue, check backpressure and order
        do_reset();
        for (int k = 0; k < 4; k++) push(0, 4'b0000, 10 + k);
        cmd_valid = 1; cmd_op = 2'd0; #1;
        chk("R4 ready full target", cmd_ready, 0);
        cmd_op = 2'd1; #1;
        chk("R4 ready other target", cmd_ready, 1);
        cmd_op = 2'd3; #1;
        chk("R4 ready discard", cmd_ready, 1);
        cmd_valid = 0;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            take(0, 10 + k, "R3 order");
            done(0);
        end
        chk("R3 drained", ld_valid, 0);

        // R10 hold while not ready
        push(0, 4'b0000, 77);
        for (int k = 0; k < 3; k++) begin
            chk("R10 hold valid", ld_valid, 1);
            chk("R10 hold data", ld_data, 77);
            @(negedge clk);
        end
        take(0, 77, "R10 release");
        done(0);

        // R5/R6 execute waits on load-to-execute token
        do_reset();
        push(2, 4'b0001, 5);
        chk("R5 ex stalled", ex_valid, 0);
        push(0, 4'b0010, 6);
        chk("R5 ex stalled before completion", ex_valid, 0);
        take(0, 6, "R6 load");
        chk("R6 ex stalled until done", ex_valid, 0);
        done(0);
        chk("R6 ex released", ex_valid, 1);
        push(2, 4'b0001, 7);
        take(2, 5, "R5 ex issue");
        chk("R5 token consumed", ex_valid, 0);

        // R5 load waits on execute-to-load token
        do_reset();
        push(0, 4'b0001, 30);
        chk("R5 ld stalled", ld_valid, 0);
        push(2, 4'b1010, 31);
        take(2, 31, "R5 ex");
        done(2);
        chk("R6 ld released", ld_valid, 1);
        push(1, 4'b0001, 32);
        chk("R6 st released", st_valid, 1);
        take(0, 30, "R5 ld");
        take(1, 32, "R5 st");

        // R7 load/store upper bits ignored
        do_reset();
        push(0, 4'b1100, 40);
        take(0, 40, "R7 ld");
        done(0);
        push(1, 4'b1100, 41);
        take(1, 41, "R7 st");
        done(1);
        push(2, 4'b0100, 42);
        chk("R7 no store token", ex_valid, 0);
        push(2, 4'b0001, 43);
        chk("R7 ex still stalled", ex_valid, 0);
        push(1, 4'b0010, 44);
        take(1, 44, "R6 st");
        done(1);
        chk("R6 store token", ex_valid, 1);
        take(2, 42, "R6 ex");
        chk("R7 no load token", ex_valid, 0);

        // R8 saturation and sticky error
        do_reset();
        for (int k = 0; k < 4; k++) begin
            push(0, 4'b0010, 50 + k);
            take(0, 50 + k, "R8 ld");
            done(0);
            chk("R8 err", tok_err, (k == 3) ? 1 : 0);
        end
        for (int k = 0; k < 3; k++) begin
            push(2, 4'b0001, 60 + k);
            take(2, 60 + k, "R8 saturated tokens");
            done(2);
        end
        push(2, 4'b0001, 63);
        chk("R8 only max tokens", ex_valid, 0);
        chk("R8 err sticky", tok_err, 1);

        // R9 consume and produce same counter in one cycle
        do_reset();
        push(0, 4'b0010, 70);
        take(0, 70, "R9 ld a");
        done(0);
        push(0, 4'b0010, 71);
        take(0, 71, "R9 ld b");
        push(2, 4'b0001, 72);
        push(2, 4'b0001, 73);
        chk("R9 ex offered", ex_valid, 1);
        ex_ready = 1; ld_done = 1;
        @(negedge clk);
        ex_ready = 0; ld_done = 0;
        chk("R9 one token left", ex_valid, 1);
        chk("R9 err", tok_err, 0);
        take(2, 73, "R9 ex b");
        done(2);
        done(2);
        push(2, 4'b0001, 74);
        chk("R9 tokens exhausted", ex_valid, 0);

        summary();
        $finish;
    end
endmodule